// File: doc/BRIEF.md
# Fractional UART Baud Rate Generator

This block derives the receive and transmit bit-rate strobes of a UART from the core clock. The core clock is first cut down by a power-of-two prescaler, whose exponent is held in a control register. It then passes through a fractional divider that divides by (64 + N)/64, where N is an 8-bit ratio register. Two divide-by-16 stages follow, one for Rx and one for Tx, and they produce single-cycle clock enables at the bit rate. The mean bit rate is 4·f_core / (2^DIV · (64 + N)). This lets a core clock of 1.5725 MHz with DIV = 3 and N = 18 give about 9588 bps.

An enable bit in the control register decides where the Rx/Tx enables come from. When the bit is set, they come from this generator. When it is clear, the legacy timer-derived enables pass through unchanged. A write to either register restarts the whole divider chain, so a new rate begins with no partial period. Software can also restart the Rx divide-by-16 stage alone, to line it up with a start bit, while the Tx stage keeps running.

Top module: `uart_frac_baud_gen`

## Requirements
- R1: The ratio register is 8 bits wide, resets to 0x00, is loaded by `frac_we` and is read back on `frac_q`. It holds its value when it is not written.
- R2: The control register resets to 0x00 and is loaded by `ctrl_we`. Bit 7 is the enable and bits 2:0 are the prescale exponent DIV. Bits 6:3 ignore writes and read as zero, so writing 0xFF reads back 0x87.
- R3: With the enable clear, `rx_tick` equals `legacy_rx_tick` and `tx_tick` equals `legacy_tx_tick` in the same cycle.
- R4: With the enable set, the legacy enables have no effect on the outputs.
- R5: With the enable set, the generator gives exactly 64 Tx pulses (and, with no Rx restart, 64 Rx pulses) per 16·2^DIV·(64+N) core cycles. Over any long window the count is within one pulse of window·4/(2^DIV·(64+N)).
- R6: Generated pulses last exactly one core cycle and are never on in two consecutive cycles.
- R7: A write to either register clears the prescaler, the accumulator and both divide-by-16 counters. No generated pulse appears in the cycle after the write. With DIV = 0 and N = 0, the first Tx pulse is high in the cycle after the 16th clock edge that follows the write edge.
- R8: Asserting `rx_restart` at a clock edge clears only the Rx divide-by-16 counter. The next Rx pulse follows 16 fractional steps later, and Tx timing is unaffected.
- R9: With DIV = 3 and N = 18, the first and third Tx pulses after a write are exactly 328 core cycles apart, an average of 164 cycles per bit (about 9588 bps at 1.5725 MHz).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control write data (bit 7 enable, bits 2:0 DIV) |
| frac_we | input | 1 | Ratio register write strobe |
| frac_wdata | input | 8 | Ratio write data N |
| rx_restart | input | 1 | Clear the Rx divide-by-16 counter |
| legacy_rx_tick | input | 1 | Timer-derived Rx enable, used when disabled |
| legacy_tx_tick | input | 1 | Timer-derived Tx enable, used when disabled |
| ctrl_q | output | 8 | Control register readback |
| frac_q | output | 8 | Ratio register readback |
| rx_tick | output | 1 | Rx bit-rate clock enable |
| tx_tick | output | 1 | Tx bit-rate clock enable |

## Verification
The pulse-spacing properties assume that no register write and no Rx restart arrives between two generated pulses that are being compared. The write-clear properties only reason about writes to the ratio register that leave the enable unchanged. The stimulus keeps every write and restart isolated to a single cycle, and it drives them only at the start of a measurement, never inside a counting window. Legacy enables are toggled freely, since the properties only look at output pulses while the enable is set.

// File: rtl/uart_frac_baud_gen.sv
module uart_frac_baud_gen #(
  parameter int DIV_W = 3,
  parameter int FD_W  = 8,
  parameter int ONE   = 64,
  parameter int OVS   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_we,
  input  logic [7:0] ctrl_wdata,
  input  logic       frac_we,
  input  logic [7:0] frac_wdata,
  input  logic       rx_restart,
  input  logic       legacy_rx_tick,
  input  logic       legacy_tx_tick,
  output logic [7:0] ctrl_q,
  output logic [7:0] frac_q,
  output logic       rx_tick,
  output logic       tx_tick
);
  localparam int PW = (1 << DIV_W) - 1;
  localparam int AW = FD_W + 2;
  localparam int CW = $clog2(OVS);

  logic             en_q;
  logic [DIV_W-1:0] div_q;
  logic [FD_W-1:0]  fd_q;
  logic [PW-1:0]    pcnt;
  logic [AW-1:0]    acc_q;
  logic [CW-1:0]    rx_cnt, tx_cnt;
  logic             rx_pls, tx_pls;

  wire clr = ctrl_we | frac_we;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q  <= 1'b0;
      div_q <= '0;
    end else if (ctrl_we) begin
      en_q  <= ctrl_wdata[7];
      div_q <= ctrl_wdata[DIV_W-1:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       fd_q <= '0;
    else if (frac_we) fd_q <= frac_wdata[FD_W-1:0];

  assign ctrl_q = {en_q, {(7-DIV_W){1'b0}}, div_q};
  assign frac_q = 8'(fd_q);

  wire [PW-1:0] lim       = ~({PW{1'b1}} << div_q);
  wire          presc_hit = (pcnt == lim);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                pcnt <= '0;
    else if (clr || presc_hit) pcnt <= '0;
    else                       pcnt <= pcnt + 1'b1;

  wire [AW-1:0] sum      = acc_q + AW'(ONE);
  wire [AW-1:0] modulus  = AW'(ONE) + AW'(fd_q);
  wire          frac_hit = presc_hit && (sum >= modulus);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         acc_q <= '0;
    else if (clr)       acc_q <= '0;
    else if (frac_hit)  acc_q <= sum - modulus;
    else if (presc_hit) acc_q <= sum;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_cnt <= '0;
      tx_pls <= 1'b0;
    end else begin
      tx_pls <= !clr && frac_hit && (tx_cnt == CW'(OVS-1));
      if (clr)           tx_cnt <= '0;
      else if (frac_hit) tx_cnt <= tx_cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_cnt <= '0;
      rx_pls <= 1'b0;
    end else begin
      rx_pls <= !clr && !rx_restart && frac_hit && (rx_cnt == CW'(OVS-1));
      if (clr || rx_restart) rx_cnt <= '0;
      else if (frac_hit)     rx_cnt <= rx_cnt + 1'b1;
    end

  assign rx_tick = en_q ? rx_pls : legacy_rx_tick;
  assign tx_tick = en_q ? tx_pls : legacy_tx_tick;
endmodule

// File: rtl/uart_frac_baud_gen_chk.sv
module uart_frac_baud_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctrl_we,
  input logic       frac_we,
  input logic       rx_restart,
  input logic [7:0] ctrl_q,
  input logic [7:0] frac_q,
  input logic       rx_tick,
  input logic       tx_tick
);
  a_r1_frac_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frac_we |=> $stable(frac_q));

  a_r2_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_we |=> $stable(ctrl_q));

  a_r6_tx_single: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[7] && tx_tick) |=> !(ctrl_q[7] && tx_tick));

  a_r6_rx_single: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[7] && rx_tick) |=> !(ctrl_q[7] && rx_tick));

  a_r7_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (frac_we && !ctrl_we && ctrl_q[7]) |=> (!tx_tick && !rx_tick));

  a_r8_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_restart && !ctrl_we && ctrl_q[7]) |=> !rx_tick);
endmodule

bind uart_frac_baud_gen uart_frac_baud_gen_chk i_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .frac_we(frac_we),
  .rx_restart(rx_restart), .ctrl_q(ctrl_q), .frac_q(frac_q),
  .rx_tick(rx_tick), .tx_tick(tx_tick)
);

// File: tb/test_uart_frac_baud_gen.sv
module test_uart_frac_baud_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = 8000;
  localparam int NV = 5;
  localparam logic [15:0] VEC [NV] = '{16'h0000, 16'h0312, 16'h01FF, 16'h0207, 16'h0564};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl_we = 1'b0, frac_we = 1'b0, rx_restart = 1'b0;
  logic [7:0] ctrl_wdata = '0, frac_wdata = '0;
  logic legacy_rx_tick = 1'b0, legacy_tx_tick = 1'b0;
  logic [7:0] ctrl_q, frac_q;
  logic rx_tick, tx_tick;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_frac_baud_gen i_uart_frac_baud_gen (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .frac_we(frac_we), .frac_wdata(frac_wdata), .rx_restart(rx_restart),
    .legacy_rx_tick(legacy_rx_tick), .legacy_tx_tick(legacy_tx_tick),
    .ctrl_q(ctrl_q), .frac_q(frac_q), .rx_tick(rx_tick), .tx_tick(tx_tick)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_near(input string req, input int act, input int exp);
    total++;
    if (act > exp + 1 || act < exp - 1) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (+/-1)", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [7:0] d);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = d;
    @(posedge clk); #1; ctrl_we = 1'b0;
  endtask

  task automatic wr_frac(input logic [7:0] d);
    @(negedge clk); frac_we = 1'b1; frac_wdata = d;
    @(posedge clk); #1; frac_we = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int rxc, txc, first_tx, first_rx, t1, t3, n;
    repeat (3) @(posedge clk);
    #1;
    check("R2 reset ctrl", ctrl_q, 0);
    check("R1 reset frac", frac_q, 0);
    check("R3 reset ticks", {rx_tick, tx_tick}, 0);
    rst_n = 1'b1;

    wr_ctrl(8'hFF);
    check("R2 unused bits read zero", ctrl_q, 8'h87);
    wr_frac(8'hA5);
    check("R1 frac readback", frac_q, 8'hA5);

    wr_ctrl(8'h00);
    legacy_rx_tick = 1'b1; legacy_tx_tick = 1'b0; #1;
    check("R3 pass rx", rx_tick, 1);
    check("R3 pass tx", tx_tick, 0);
    legacy_rx_tick = 1'b0; legacy_tx_tick = 1'b1; #1;
    check("R3 pass swap", {rx_tick, tx_tick}, 2'b01);

    for (int v = 0; v < NV; v++) begin
      int d, f, exp;
      d = int'(VEC[v][15:8]); f = int'(VEC[v][7:0]);
      wr_ctrl(8'h80 | 8'(d));
      wr_frac(8'(f));
      rxc = 0; txc = 0;
      for (int k = 0; k < WIN; k++) begin
        @(posedge clk); #1;
        legacy_rx_tick = k[0]; legacy_tx_tick = ~k[0];
        rxc += int'(rx_tick); txc += int'(tx_tick);
      end
      exp = (WIN * 4) / ((1 << d) * (64 + f));
      check_near($sformatf("R5 tx rate div=%0d fd=%0d", d, f), txc, exp);
      check_near($sformatf("R5 rx rate div=%0d fd=%0d", d, f), rxc, exp);
    end

    wr_ctrl(8'h80);
    legacy_rx_tick = 1'b1; legacy_tx_tick = 1'b1;
    wr_frac(8'h00);
    check("R7 quiet after write", {rx_tick, tx_tick}, 0);
    first_tx = 0; n = 0;
    for (int k = 1; k <= 40; k++) begin
      @(posedge clk); #1;
      if (k <= 10) n += int'(tx_tick) + int'(rx_tick);
      if (tx_tick && first_tx == 0) first_tx = k;
    end
    check("R4 legacy ignored", n, 0);
    check("R7 first tx edge", first_tx, 16);

    legacy_rx_tick = 1'b0; legacy_tx_tick = 1'b0;
    wr_frac(8'h00);
    first_tx = 0; first_rx = 0; n = 0;
    for (int k = 1; k <= 40; k++) begin
      @(posedge clk); #1;
      if (rx_tick && first_rx == 0) first_rx = k;
      if (tx_tick && first_tx == 0) first_tx = k;
      if (tx_tick && k > 16 && n == 0) n = k;
      rx_restart = (k == 4);
    end
    rx_restart = 1'b0;
    check("R8 rx after restart", first_rx, 21);
    check("R8 tx unaffected first", first_tx, 16);
    check("R8 tx unaffected second", n, 32);

    wr_ctrl(8'h83);
    wr_frac(8'd18);
    t1 = 0; t3 = 0; n = 0;
    for (int k = 1; k <= 700; k++) begin
      @(posedge clk); #1;
      if (tx_tick) begin
        n++;
        if (n == 1) t1 = k;
        if (n == 3) t3 = k;
      end
    end
    check("R9 two-bit span", t3 - t1, 328);
    check("R6 pulses in window", n, 4);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule